// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank

This block produces a set of divided clock enables from a single fast clock. A source tick is chosen from one of two tick inputs: the reference tick in bypass, or the PLL tick. A common post-divider may scale it down. A bank of channel dividers then reduces that base tick further. Every output is a single-cycle enable pulse in the `clk` domain, so downstream logic runs from `clk` and qualifies its work with the pulse.

Software programs the post-divider and the channel dividers through a small register port. The new values go into shadow registers first. They reach the counters only when a GO command is written. The block then raises a busy flag. On the next source tick it loads every divider at once and restarts all the counters together, so the outputs start phase-aligned, and it clears the flag. One channel always runs at a quarter of channel 0's rate. An observation divider can further divide any channel's output, which makes that channel easy to measure.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, STAT (address 2) reads 0, POST (address 3) reads 0x8000, DIV0 (address 4) reads 0x8000, DIV3 (address 7) reads 0x8003, and with no source ticks every `sys_ce` bit is 0.
- R2: A channel whose active register holds bit 15 = 1 and ratio field N (low bits) emits exactly one `sys_ce` pulse per N+1 base ticks. Counting starts at the last alignment point or at reset.
- R3: CTRL bit 0 = 0 selects `ref_ce` as the source tick, and 1 selects `pll_ce`. Ticks on the unselected input have no effect on any output.
- R4: POST (address 3) with bit 15 = 1 and ratio M makes one base tick per M+1 source ticks. With bit 15 = 0 every source tick is a base tick.
- R5: Writes to POST or to DIVc (address 4+c) update only a shadow copy that reads back at once. Output rates keep the old settings until a GO is written (CMD, address 1, bit 0 = 1) and the alignment completes.
- R6: STAT bit 0 reads 1 from the cycle after a GO write. It returns to 0 after the first selected source tick, which is the alignment point.
- R7: While STAT bit 0 is 1, writes to POST or to any DIV register are ignored, and so is a further GO.
- R8: At the alignment point no output pulses. All divider counters, including the observation divider, restart together, so channels with divisors Da and Db pulse in the same cycle every lcm(Da,Db) base ticks.
- R9: A channel whose active bit 15 is 0 never pulses.
- R10: Channel 3 takes only its enable bit from DIV3. Its ratio field reads back and acts as 4*(N0+1)-1, where N0 is the channel 0 shadow ratio.
- R11: OBSDIV (address 12) with bit 15 = 1 and ratio K in bits 7:0 makes `obs_ce` pulse once per K+1 pulses of the channel chosen by OBSSEL (address 13, bits 1:0). These two registers take effect immediately, and with bit 15 = 0 `obs_ce` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all logic and outputs are in this domain |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_ce | input | 1 | Tick from the PLL output |
| ref_ce | input | 1 | Tick from the reference (bypass) clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data, combinational from `addr` |
| sys_ce | output | NCH | Per-channel divided clock-enable pulses |
| obs_ce | output | 1 | Observation divider pulse |

## Verification
The source ticks are random. Pulses are counted over windows that hold a fixed number of selected source ticks, chosen as a common multiple of every divisor in play. Each count must then equal the window divided by that channel's divisor. The windows come right after reset, before a GO with new shadow values pending, and after GO. This tells a correct shadow hold apart from an early apply, and the PLL source apart from the reference source. A directed GO with the source ticks held off keeps the busy flag up long enough to test ignored writes. A count of coincident pulses on two channels shows that the restart is truly common. Random rounds vary the ratios, enables, post-divider, source and observation settings. A divide-by-26 observation case covers a large observation ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int EN_BIT = 15;

  localparam logic [AW-1:0] A_CTRL   = 4'h0;
  localparam logic [AW-1:0] A_CMD    = 4'h1;
  localparam logic [AW-1:0] A_STAT   = 4'h2;
  localparam logic [AW-1:0] A_POST   = 4'h3;
  localparam logic [AW-1:0] A_DIV0   = 4'h4;
  localparam logic [AW-1:0] A_OBSDIV = 4'hC;
  localparam logic [AW-1:0] A_OBSSEL = 4'hD;

  // divide factor realised by a ratio field value
  function automatic int unsigned div_factor(input int unsigned ratio);
    return ratio + 1;
  endfunction

  // ratio field of the channel locked to a quarter of channel 0
  function automatic int unsigned quarter_ratio(input int unsigned ratio0);
    return div_factor(ratio0) * 4 - 1;
  endfunction
endpackage

// File: rtl/clkdiv_cnt.sv
module clkdiv_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic         wrap;

  // >= keeps a lowered ratio from running the counter the long way round
  assign wrap  = (cnt >= ratio);
  assign pulse = en & tick & ~clr & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int RW     = 5,
  parameter int CW     = 7,
  parameter int OW     = 8,
  parameter int SW     = 2,
  parameter int FIX_CH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   src_tick,
  output logic                   src_sel,
  output logic                   busy,
  output logic                   align_evt,
  output logic [NCH-1:0]         act_en,
  output logic [NCH-1:0][CW-1:0] act_ratio,
  output logic                   post_en,
  output logic [CW-1:0]          post_ratio,
  output logic                   obs_en,
  output logic [OW-1:0]          obs_ratio,
  output logic [SW-1:0]          obs_sel,
  output logic [DW-1:0]          rd_data
);
  logic [NCH-1:0]         sh_en;
  logic [NCH-1:0][RW-1:0] sh_ratio;
  logic                   sh_post_en;
  logic [RW-1:0]          sh_post_ratio;
  logic [CW-1:0]          fix_ratio;
  logic                   cfg_wr;
  logic                   go_req;

  assign cfg_wr    = wr_en & ~busy;
  assign go_req    = cfg_wr & (addr == A_CMD) & wr_data[0];
  assign align_evt = busy & src_tick;
  assign fix_ratio = CW'(quarter_ratio(int'(sh_ratio[0])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_sel       <= 1'b0;
      busy          <= 1'b0;
      sh_en         <= '1;
      sh_ratio      <= '0;
      sh_post_en    <= 1'b1;
      sh_post_ratio <= '0;
      post_en       <= 1'b1;
      post_ratio    <= '0;
      act_en        <= '1;
      for (int i = 0; i < NCH; i++)
        act_ratio[i] <= (i == FIX_CH) ? CW'(quarter_ratio(0)) : '0;
      obs_en        <= 1'b0;
      obs_ratio     <= '0;
      obs_sel       <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) src_sel <= wr_data[0];
      if (wr_en && addr == A_OBSDIV) begin
        obs_en    <= wr_data[EN_BIT];
        obs_ratio <= wr_data[OW-1:0];
      end
      if (wr_en && addr == A_OBSSEL) obs_sel <= wr_data[SW-1:0];
      if (cfg_wr && addr == A_POST) begin
        sh_post_en    <= wr_data[EN_BIT];
        sh_post_ratio <= wr_data[RW-1:0];
      end
      for (int i = 0; i < NCH; i++) begin
        if (cfg_wr && addr == A_DIV0 + AW'(i)) begin
          sh_en[i]    <= wr_data[EN_BIT];
          sh_ratio[i] <= wr_data[RW-1:0];
        end
      end
      if (go_req)         busy <= 1'b1;
      else if (align_evt) busy <= 1'b0;
      if (align_evt) begin
        post_en    <= sh_post_en;
        post_ratio <= CW'(sh_post_ratio);
        act_en     <= sh_en;
        for (int i = 0; i < NCH; i++)
          act_ratio[i] <= (i == FIX_CH) ? fix_ratio : CW'(sh_ratio[i]);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_CTRL) rd_data[0] = src_sel;
    if (addr == A_STAT) rd_data[0] = busy;
    if (addr == A_POST) begin
      rd_data[EN_BIT]  = sh_post_en;
      rd_data[RW-1:0]  = sh_post_ratio;
    end
    if (addr == A_OBSDIV) begin
      rd_data[EN_BIT]  = obs_en;
      rd_data[OW-1:0]  = obs_ratio;
    end
    if (addr == A_OBSSEL) rd_data[SW-1:0] = obs_sel;
    for (int i = 0; i < NCH; i++) begin
      if (addr == A_DIV0 + AW'(i)) begin
        rd_data[EN_BIT]  = sh_en[i];
        rd_data[CW-1:0]  = (i == FIX_CH) ? fix_ratio : CW'(sh_ratio[i]);
      end
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int RW     = 5,
  parameter int OW     = 8,
  parameter int FIX_CH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pll_ce,
  input  logic           ref_ce,
  input  logic           wr_en,
  input  logic [3:0]     addr,
  input  logic [15:0]    wr_data,
  output logic [15:0]    rd_data,
  output logic [NCH-1:0] sys_ce,
  output logic           obs_ce
);
  localparam int CW = RW + 2;
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

  logic                   src_sel;
  logic                   src_tick;
  logic                   busy;
  logic                   align_evt;
  logic                   base_tick;
  logic                   post_pulse;
  logic                   post_en;
  logic [CW-1:0]          post_ratio;
  logic [NCH-1:0]         act_en;
  logic [NCH-1:0][CW-1:0] act_ratio;
  logic                   obs_en;
  logic [OW-1:0]          obs_ratio;
  logic [SW-1:0]          obs_sel;
  logic                   obs_src;

  assign src_tick = src_sel ? pll_ce : ref_ce;

  clkdiv_regs #(
    .NCH(NCH), .RW(RW), .CW(CW), .OW(OW), .SW(SW), .FIX_CH(FIX_CH)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .src_tick(src_tick), .src_sel(src_sel), .busy(busy), .align_evt(align_evt),
    .act_en(act_en), .act_ratio(act_ratio), .post_en(post_en),
    .post_ratio(post_ratio), .obs_en(obs_en), .obs_ratio(obs_ratio),
    .obs_sel(obs_sel), .rd_data(rd_data)
  );

  clkdiv_cnt #(.W(CW)) post_i (
    .clk(clk), .rst_n(rst_n), .clr(align_evt), .tick(src_tick), .en(1'b1),
    .ratio(post_ratio), .pulse(post_pulse)
  );

  assign base_tick = post_en ? post_pulse : (src_tick & ~align_evt);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    clkdiv_cnt #(.W(CW)) chan_i (
      .clk(clk), .rst_n(rst_n), .clr(align_evt), .tick(base_tick),
      .en(act_en[c]), .ratio(act_ratio[c]), .pulse(sys_ce[c])
    );
  end

  assign obs_src = sys_ce[obs_sel];

  clkdiv_cnt #(.W(OW)) obs_i (
    .clk(clk), .rst_n(rst_n), .clr(align_evt | ~obs_en), .tick(obs_src),
    .en(obs_en), .ratio(obs_ratio), .pulse(obs_ce)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [3:0]             addr,
  input logic [15:0]            wr_data,
  input logic                   src_tick,
  input logic                   busy,
  input logic                   align_evt,
  input logic                   base_tick,
  input logic                   post_en,
  input logic [NCH-1:0]         act_en,
  input logic [NCH-1:0][CW-1:0] act_ratio,
  input logic [NCH-1:0]         sys_ce,
  input logic                   obs_ce
);
  a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h1 && wr_data[0] && !busy) |=> busy);

  a_r6_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src_tick) |=> !busy);

  a_r8_quiet_align: assert property (@(posedge clk) disable iff (!rst_n)
    align_evt |-> (sys_ce == '0 && !obs_ce));

  a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !align_evt |=> ($stable(act_ratio) && $stable(act_en)));

  a_r2_pulse_on_base: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_ce != '0) |-> base_tick);

  a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !post_en |-> (base_tick == (src_tick && !align_evt)));

  for (genvar c = 0; c < NCH; c++) begin : g_off
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !act_en[c] |-> !sys_ce[c]);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .src_tick(src_tick), .busy(busy), .align_evt(align_evt),
  .base_tick(base_tick), .post_en(post_en), .act_en(act_en),
  .act_ratio(act_ratio), .sys_ce(sys_ce), .obs_ce(obs_ce)
);

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb_top;
  localparam int PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pll_ce = 1'b0, ref_ce = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [NCH-1:0] sys_ce;
  logic obs_ce;

  int checks = 0, errors = 0;
  int cnt [NCH];
  int obs_n, both_n, src_n;
  bit bbusy = 0, bsel = 0, done = 0;
  logic [15:0] rdv;

  always #(PERIOD/2) clk = ~clk;

  clkdiv_bank dut_i (
    .clk(clk), .rst_n(rst_n), .pll_ce(pll_ce), .ref_ce(ref_ce),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .sys_ce(sys_ce), .obs_ce(obs_ce)
  );

  function automatic int exp_div(input int r);
    return r + 1;
  endfunction

  function automatic int exp_quarter_div(input int r0);
    return 4 * exp_div(r0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit allow, input bit we, input logic [3:0] a,
                      input logic [15:0] d);
    bit st;
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d;
    pll_ce = allow ? ($urandom % 2 == 1) : 1'b0;
    ref_ce = allow ? ($urandom % 4 == 0) : 1'b0;
    #1;
    rdv = rd_data;
    st = bsel ? pll_ce : ref_ce;
    if (bbusy && st) begin
      checks++;
      if (sys_ce != '0 || obs_ce) begin
        errors++;
        $display("FAIL R8 pulse at align actual=%0h expected=0", {obs_ce, sys_ce});
      end
      bbusy = 0;
    end else if (st) begin
      src_n++;
      for (int i = 0; i < NCH; i++) cnt[i] += int'(sys_ce[i]);
      obs_n += int'(obs_ce);
      both_n += int'(sys_ce[0] & sys_ce[1]);
    end
    if (we && a == 4'h1 && d[0] && !bbusy) bbusy = 1;
    if (we && a == 4'h0) bsel = d[0];
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(0, 1, a, d);
  endtask

  task automatic rd(input logic [3:0] a);
    step(0, 0, a, 16'h0);
  endtask

  task automatic wait_align();
    while (bbusy) step(1, 0, 4'h0, 16'h0);
  endtask

  task automatic run_window(input int s);
    for (int i = 0; i < NCH; i++) cnt[i] = 0;
    obs_n = 0; both_n = 0; src_n = 0;
    while (src_n < s) step(1, 0, 4'h0, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(4'h0); chk("R1 CTRL", int'(rdv), 0);
    rd(4'h2); chk("R1 STAT", int'(rdv), 0);
    rd(4'h3); chk("R1 POST", int'(rdv), 16'h8000);
    rd(4'h4); chk("R1 DIV0", int'(rdv), 16'h8000);
    rd(4'h7); chk("R1 DIV3", int'(rdv), 16'h8003);
    chk("R1 sys_ce idle", int'(sys_ce), 0);

    // R2 R3 R10 window from reset on the reference tick
    run_window(24);
    chk("R2 ch0 div1", cnt[0], 24);
    chk("R3 ref source ch1", cnt[1], 24);
    chk("R10 ch3 quarter", cnt[3], 24 / exp_quarter_div(0));

    // R5 shadow writes stay pending
    wr(4'h4, 16'h8001);
    wr(4'h5, 16'h8002);
    wr(4'h6, 16'h0005);
    wr(4'h7, 16'h801F);
    wr(4'h3, 16'h8001);
    rd(4'h4); chk("R5 DIV0 shadow readback", int'(rdv), 16'h8001);
    rd(4'h7); chk("R10 DIV3 derived", int'(rdv), 16'h8000 | (exp_quarter_div(1) - 1));
    run_window(20);
    chk("R5 ch0 old rate", cnt[0], 20);
    chk("R5 ch2 still on", cnt[2], 20);

    // R6 R7 GO with ticks held off
    wr(4'h0, 16'h0001);
    wr(4'h1, 16'h0001);
    rd(4'h2); chk("R6 busy set", int'(rdv[0]), 1);
    wr(4'h5, 16'h8009);
    wr(4'h3, 16'h0000);
    rd(4'h5); chk("R7 DIV1 write ignored", int'(rdv), 16'h8002);
    rd(4'h3); chk("R7 POST write ignored", int'(rdv), 16'h8001);
    wait_align();
    rd(4'h2); chk("R6 busy clear", int'(rdv[0]), 0);

    // R3 R4 R8 R9 after GO on the PLL tick, post /2, window 24 base ticks
    run_window(48);
    chk("R4 R2 ch0 /2 after post /2", cnt[0], 12);
    chk("R2 ch1 /3", cnt[1], 8);
    chk("R9 ch2 disabled", cnt[2], 0);
    chk("R10 ch3 /8", cnt[3], 3);
    chk("R8 ch0 ch1 coincide", both_n, 4);

    // R11 R4 observation /26, post disabled, reference source
    wr(4'h0, 16'h0000);
    wr(4'h4, 16'h8000);
    wr(4'h5, 16'h8000);
    wr(4'h6, 16'h8000);
    wr(4'h3, 16'h0005);
    wr(4'hD, 16'h0000);
    wr(4'hC, 16'h8019);
    wr(4'h1, 16'h0001);
    wait_align();
    run_window(52);
    chk("R4 post disabled passthrough", cnt[0], 52);
    chk("R10 ch3 /4", cnt[3], 13);
    chk("R11 obs /26", obs_n, 2);

    // random rounds, window 96 base ticks
    for (int k = 0; k < 4; k++) begin
      int r [3];
      int p, o, sl, e2, s, d [NCH];
      for (int i = 0; i < 3; i++) r[i] = int'($urandom % 4);
      e2 = int'($urandom % 2);
      p  = int'($urandom % 3);
      o  = int'($urandom % 2);
      sl = int'($urandom % 4);
      s  = int'($urandom % 2);
      wr(4'h0, 16'(s));
      wr(4'h4, 16'h8000 | 16'(r[0]));
      wr(4'h5, 16'h8000 | 16'(r[1]));
      wr(4'h6, (e2 != 0 ? 16'h8000 : 16'h0000) | 16'(r[2]));
      wr(4'h7, 16'h8000);
      wr(4'h3, 16'h8000 | 16'(p));
      wr(4'hD, 16'(sl));
      wr(4'hC, 16'h8000 | 16'(o));
      wr(4'h1, 16'h0001);
      wait_align();
      run_window(96 * exp_div(p));
      d[0] = exp_div(r[0]); d[1] = exp_div(r[1]); d[2] = exp_div(r[2]);
      d[3] = exp_quarter_div(r[0]);
      chk("R2 rand ch0", cnt[0], 96 / d[0]);
      chk("R2 rand ch1", cnt[1], 96 / d[1]);
      chk("R9 rand ch2", cnt[2], e2 != 0 ? 96 / d[2] : 0);
      chk("R10 rand ch3", cnt[3], 96 / d[3]);
      chk("R11 rand obs", obs_n,
          (sl == 2 && e2 == 0) ? 0 : 96 / (d[sl] * exp_div(o)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule